// File: doc/BRIEF.md
# Byte-Wide Configuration and Coefficient Port

This block is the host-side register port of a decimating filter engine. A host reaches it over an 8-bit data path with a 3-bit address and two active-low strobes, one for writes and one for reads. Both strobes are sampled in the block's system clock. A write takes effect on the falling edge of the write strobe that the block detects. A read drives the addressed contents for as long as the read strobe stays low. There is no tristate buffer: the read data leaves the block on its own bus, together with an output-enable.

Seven of the eight addresses are plain byte registers. The register at address 0 is also decoded into the control fields the filter engine uses, and the register at address 1 is decoded into a tap count. Address 2 is not a register. It is a window onto a 128-entry memory of 32-bit coefficients. Each coefficient is loaded as four successive byte writes, least significant byte first, and an auto-incrementing pointer selects the entry. A mode bit in register 0 decides whether this window accepts writes or returns read-back bytes. The filter engine reads the coefficient memory through a separate combinational port.

Top module: `coef_cfg_port`

## Requirements
- R1: After reset all eight registers and all coefficient entries are zero, the pointer and byte counter are zero, `host_rd_oe` is low, `host_rdata` is zero, `fir_decim` reads 8 and `fir_taps` reads 256.
- R2: A write to address 1 or 3..7 stores `host_wdata` in that register, which then appears in `cfg_regs` at bits [8k+7:8k] and is returned by a read of the same address.
- R3: Register 0 decodes as follows. Bits [2:0] give `hb_stages`, with `hb_stages_bad` high when the value exceeds 5. Bit 3 gives `filt_en` and bit 4 gives `coef_rd_en`. Bits [7:5] give `fir_decim`, where 0 encodes 8.
- R4: `fir_taps` equals register 1, except that 0 encodes 256. `fir_taps_bad` is high when register 1 holds 1, 2 or 3.
- R5: While `coef_rd_en` is 0, writes to address 2 fill a coefficient least significant byte first. The entry is unchanged after three bytes. After the fourth byte it holds the full word, and the pointer moves to the next entry.
- R6: The pointer saturates after entry 127 has been written. Further coefficient writes are discarded, and no earlier entry is overwritten.
- R7: While `coef_rd_en` is 1, writes to address 2 are ignored. Reads of address 2 return the entry's bytes least significant first, and the pointer advances after every fourth read. While `coef_rd_en` is 0, a read of address 2 returns 0 and does not advance the pointer.
- R8: `host_rd_oe` is high only while a read is in progress and is low again once the read strobe has returned high. `host_rdata` is 0 whenever `host_rd_oe` is low.
- R9: If the read and write strobes are low at the same time, neither access takes effect: no register changes and `host_rd_oe` stays low.
- R10: Any write to address 0 clears both the coefficient pointer and the byte counter, so the next coefficient access starts at byte 0 of entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rd_n | input | 1 | Active-low read strobe |
| host_rdata | output | 8 | Read data |
| host_rd_oe | output | 1 | High while read data is driven |
| cfg_regs | output | 64 | All eight registers; register k at bits [8k+7:8k] |
| hb_stages | output | 3 | Number of halfband stages |
| hb_stages_bad | output | 1 | Halfband stage count above 5 |
| filt_en | output | 1 | Filter enable |
| coef_rd_en | output | 1 | Coefficient read-back mode |
| fir_decim | output | 4 | FIR decimation rate, 1..8 |
| fir_taps | output | 9 | FIR tap count, 1..256 |
| fir_taps_bad | output | 1 | Tap count is 1, 2 or 3 |
| coef_raddr | input | 7 | Engine-side coefficient address |
| coef_rdata | output | 32 | Engine-side coefficient word |

## Verification
A strobe edge passes through one sampling register and is then detected, so every write result appears after the second rising clock edge following the falling write strobe. The read output-enable rises two edges after the read strobe falls and drops two edges after it rises. The pointer advance for read-back happens at that rising strobe. The bench drives inputs on falling clock edges, holds every strobe level for three full cycles, and samples only on falling edges after that hold. Every result is therefore observed one clear cycle after it is due, whatever the latency.

// File: rtl/coef_cfg_port.sv
module coef_cfg_port #(
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter int CW        = 32,
  parameter int DEPTH     = 128,
  parameter int COEF_ADDR = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         host_addr,
  input  logic [DW-1:0]         host_wdata,
  input  logic                  host_wr_n,
  input  logic                  host_rd_n,
  output logic [DW-1:0]         host_rdata,
  output logic                  host_rd_oe,
  output logic [(1<<AW)*DW-1:0] cfg_regs,
  output logic [2:0]            hb_stages,
  output logic                  hb_stages_bad,
  output logic                  filt_en,
  output logic                  coef_rd_en,
  output logic [3:0]            fir_decim,
  output logic [8:0]            fir_taps,
  output logic                  fir_taps_bad,
  input  logic [$clog2(DEPTH)-1:0] coef_raddr,
  output logic [CW-1:0]         coef_rdata
);
  localparam int NREG  = 1 << AW;
  localparam int NBYTE = CW / DW;
  localparam int BCW   = $clog2(NBYTE);
  localparam int IW    = $clog2(DEPTH);
  localparam int PW    = $clog2(DEPTH + 1);
  localparam logic [BCW-1:0] LAST_B = BCW'(NBYTE - 1);
  localparam logic [PW-1:0]  PEND   = PW'(DEPTH);
  localparam logic [AW-1:0]  CADDR  = AW'(COEF_ADDR);

  logic wr_s1, wr_s2, rd_s1, rd_s2;
  logic [DW-1:0] cfg_q [NREG];
  logic [CW-1:0] mem [DEPTH];
  logic [CW-DW-1:0] hold;
  logic [BCW-1:0] bcnt;
  logic [PW-1:0]  ptr;
  logic           rd_act;
  logic [AW-1:0]  rd_addr;

  logic wr_fall, rd_fall, rd_rise, ptr_ok;
  logic [IW-1:0] ptr_idx;
  logic [CW-1:0] rd_word;
  logic [DW-1:0] coef_byte;

  assign wr_fall = wr_s2 & ~wr_s1 & rd_s1;
  assign rd_fall = rd_s2 & ~rd_s1 & wr_s1;
  assign rd_rise = ~rd_s2 & rd_s1 & rd_act;
  assign ptr_ok  = ptr < PEND;
  assign ptr_idx = ptr[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_s1   <= 1'b1;
      wr_s2   <= 1'b1;
      rd_s1   <= 1'b1;
      rd_s2   <= 1'b1;
      hold    <= '0;
      bcnt    <= '0;
      ptr     <= '0;
      rd_act  <= 1'b0;
      rd_addr <= '0;
      for (int i = 0; i < NREG; i++) cfg_q[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      wr_s1 <= host_wr_n;
      wr_s2 <= wr_s1;
      rd_s1 <= host_rd_n;
      rd_s2 <= rd_s1;

      if (rd_fall) begin
        rd_act  <= 1'b1;
        rd_addr <= host_addr;
      end else if (rd_s1) begin
        rd_act <= 1'b0;
      end

      if (rd_rise && rd_addr == CADDR && coef_rd_en && ptr_ok) begin
        if (bcnt == LAST_B) begin
          bcnt <= '0;
          ptr  <= ptr + 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end

      if (wr_fall) begin
        if (host_addr == '0) begin
          cfg_q[0] <= host_wdata;
          ptr      <= '0;
          bcnt     <= '0;
        end else if (host_addr == CADDR) begin
          if (!coef_rd_en && ptr_ok) begin
            if (bcnt == LAST_B) begin
              mem[ptr_idx] <= {host_wdata, hold};
              ptr          <= ptr + 1'b1;
              bcnt         <= '0;
            end else begin
              hold[bcnt*DW +: DW] <= host_wdata;
              bcnt                <= bcnt + 1'b1;
            end
          end
        end else begin
          cfg_q[host_addr] <= host_wdata;
        end
      end
    end
  end

  assign rd_word    = ptr_ok ? mem[ptr_idx] : '0;
  assign coef_byte  = rd_word[bcnt*DW +: DW];
  assign host_rd_oe = rd_act;
  assign host_rdata = !rd_act ? '0 :
                      (rd_addr == CADDR) ? (coef_rd_en ? coef_byte : '0) :
                      cfg_q[rd_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_regs[g*DW +: DW] = cfg_q[g];
  end

  assign hb_stages     = cfg_q[0][2:0];
  assign hb_stages_bad = cfg_q[0][2:0] > 3'd5;
  assign filt_en       = cfg_q[0][3];
  assign coef_rd_en    = cfg_q[0][4];
  assign fir_decim     = (cfg_q[0][7:5] == 3'd0) ? 4'd8 : {1'b0, cfg_q[0][7:5]};
  assign fir_taps      = (cfg_q[1] == '0) ? 9'd256 : {1'b0, cfg_q[1]};
  assign fir_taps_bad  = (cfg_q[1] != '0) && (cfg_q[1] < 8'd4);
  assign coef_rdata    = mem[coef_raddr];

  // R8: data is driven only after the read strobe was seen low
  a_r8_oe_needs_rd_low: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_oe |-> !$past(host_rd_n, 2));

  // R6: pointer never passes the end of the memory
  a_r6_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PEND);

  // R5 / R10: pointer either steps by one or returns to zero
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1 || ptr == '0));

  // R9: overlapping strobes leave state untouched
  a_r9_overlap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_s1 && !rd_s1) |=> ($stable(cfg_regs) && $stable(ptr) && $stable(bcnt)));

  // R3: decimation rate always within 1..8
  a_r3_decim_range: assert property (@(posedge clk) disable iff (!rst_n)
    fir_decim >= 4'd1 && fir_decim <= 4'd8);
endmodule

// File: tb/test_coef_cfg_port.sv
`timescale 1ns/1ps
module test_coef_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr_n = 1'b1;
  logic        host_rd_n = 1'b1;
  logic [7:0]  host_rdata;
  logic        host_rd_oe;
  logic [63:0] cfg_regs;
  logic [2:0]  hb_stages;
  logic        hb_stages_bad, filt_en, coef_rd_en, fir_taps_bad;
  logic [3:0]  fir_decim;
  logic [8:0]  fir_taps;
  logic [6:0]  coef_raddr = '0;
  logic [31:0] coef_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  coef_cfg_port i_coef_cfg_port (
    .clk, .rst_n, .host_addr, .host_wdata, .host_wr_n, .host_rd_n,
    .host_rdata, .host_rd_oe, .cfg_regs, .hb_stages, .hb_stages_bad,
    .filt_en, .coef_rd_en, .fir_decim, .fir_taps, .fir_taps_bad,
    .coef_raddr, .coef_rdata);

  // {rd(1), addr(3), wdata(8), expected(8)}
  localparam int NV = 15;
  localparam logic [19:0] VEC [NV] = '{
    20'h15A00, 20'h3A500, 20'h43C00, 20'h5FF00, 20'h68100, 20'h70700,
    20'h9005A, 20'hB00A5, 20'hC003C, 20'hD00FF, 20'hE0081, 20'hF0007,
    20'h06B00, 20'h8006B, 20'h00000
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold3();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_n = 1'b0;
    hold3();
    host_wr_n = 1'b1;
    hold3();
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    host_addr = a; host_rd_n = 1'b0;
    hold3();
    d = host_rdata; oe = host_rd_oe;
    host_rd_n = 1'b1;
    hold3();
  endtask

  task automatic wcoef(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(3'd2, v[b*8 +: 8]);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg_regs", cfg_regs, 0);
    check("R1 fir_decim", fir_decim, 8);
    check("R1 fir_taps", fir_taps, 256);
    check("R1 rd_oe", host_rd_oe, 0);
    check("R1 rdata", host_rdata, 0);
    check("R1 coef0", coef_rdata, 0);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        rd(VEC[i][18:16], d, oe);
        check("R2 readback", d, VEC[i][7:0]);
        check("R8 oe during read", oe, 1);
        check("R8 oe after read", host_rd_oe, 0);
      end else begin
        wr(VEC[i][18:16], VEC[i][15:8]);
        if (VEC[i][18:16] == 3'd0 && VEC[i][15:8] == 8'h6B) begin
          check("R3 hb_stages", hb_stages, 3);
          check("R3 filt_en", filt_en, 1);
          check("R3 coef_rd_en", coef_rd_en, 0);
          check("R3 decim", fir_decim, 3);
        end
      end
    end
    check("R2 cfg_regs reg3", cfg_regs[31:24], 8'hA5);
    check("R2 cfg_regs reg7", cfg_regs[63:56], 8'h07);
    check("R4 taps 0x5A", fir_taps, 90);

    // R3 boundaries
    wr(3'd0, 8'h07); check("R3 hb bad at 7", hb_stages_bad, 1);
    wr(3'd0, 8'hE5); check("R3 hb ok at 5", hb_stages_bad, 0);
    check("R3 decim 7", fir_decim, 7);
    wr(3'd0, 8'h00); check("R3 decim 0->8", fir_decim, 8);

    // R4 boundaries
    wr(3'd1, 8'h00); check("R4 taps 256", fir_taps, 256); check("R4 bad 0", fir_taps_bad, 0);
    wr(3'd1, 8'h03); check("R4 bad 3", fir_taps_bad, 1);
    wr(3'd1, 8'h04); check("R4 ok 4", fir_taps_bad, 0); check("R4 taps 4", fir_taps, 4);

    // R5 packing
    wr(3'd2, 8'h11); wr(3'd2, 8'h22); wr(3'd2, 8'h33);
    check("R5 partial", coef_rdata, 0);
    wr(3'd2, 8'h44);
    check("R5 commit", coef_rdata, 32'h44332211);
    wcoef(32'hDEADBEEF);
    coef_raddr = 7'd1; @(negedge clk);
    check("R5 next entry", coef_rdata, 32'hDEADBEEF);

    // R7 read-back mode
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h99);
    coef_raddr = 7'd0; @(negedge clk);
    check("R7 write ignored", coef_rdata, 32'h44332211);
    rd(3'd2, d, oe); check("R7 byte0", d, 8'h11);
    rd(3'd2, d, oe); check("R7 byte1", d, 8'h22);
    rd(3'd2, d, oe); check("R7 byte2", d, 8'h33);
    rd(3'd2, d, oe); check("R7 byte3", d, 8'h44);
    rd(3'd2, d, oe); check("R7 next entry", d, 8'hEF);
    wr(3'd0, 8'h00);
    rd(3'd2, d, oe); check("R7 zero when write mode", d, 8'h00);
    rd(3'd2, d, oe);
    wr(3'd2, 8'h55); wr(3'd2, 8'h66); wr(3'd2, 8'h77); wr(3'd2, 8'h88);
    check("R7 no advance on write-mode read", coef_rdata, 32'h88776655);

    // R10 pointer and byte counter clear
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hAA); wr(3'd2, 8'hBB);
    wr(3'd0, 8'h00);
    wcoef(32'h04030201);
    check("R10 restart at entry0 byte0", coef_rdata, 32'h04030201);

    // R9 overlapping strobes
    @(negedge clk);
    host_addr = 3'd3; host_wdata = 8'h11; host_wr_n = 1'b0; host_rd_n = 1'b0;
    hold3();
    check("R9 oe stays low", host_rd_oe, 0);
    host_wr_n = 1'b1; host_rd_n = 1'b1;
    hold3();
    check("R9 reg unchanged", cfg_regs[31:24], 8'hA5);

    // R6 saturation
    wr(3'd0, 8'h00);
    for (int k = 0; k < 128; k++) wcoef(32'(k + 1));
    wcoef(32'hFFFFFFFF);
    coef_raddr = 7'd127; @(negedge clk);
    check("R6 last entry", coef_rdata, 128);
    coef_raddr = 7'd0; @(negedge clk);
    check("R6 no wrap", coef_rdata, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule